// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a performance monitor for a memory controller. It holds eleven counters. Slot 0 is a 64-bit counter that advances on every clock. Slots 1 to 10 are 32-bit counters, and each one counts the event picked by its own 7-bit select code. Software programs and reads the bank over a simple 32-bit register bus. Writes take effect on the next clock. Reads are combinational from the address.

Any counter can be stopped through its local freeze bit. The whole bank can be stopped through a global freeze bit, which outranks every local setting. A counter that has its overflow condition armed raises an interrupt when an increment moves its most significant bit from 0 to 1, provided the global interrupt enable and freeze-on-condition enable are both set. In that case the hardware sets the global freeze bit on the same edge, so every counter stops there. Software restarts the bank by clearing the offending MSB and the global freeze bit.

Three of the event counters can also count read transactions, write transactions or read beats. A transaction only counts when its ID passes an 18-bit ID/mask comparison.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every register reads zero, the global freeze bit is clear and `irq` is low.
- R2: The slot 0 counter adds one on every clock edge while neither the global freeze nor its local freeze is set. Its low word is at 0x58 and its high word at 0x5C. Writing either word does not touch the other.
- R3: For slot n (1..10), a select code c in 0..63 counts `refEvt[c]`. A code in 64..73 counts `specEvt[(n-1)*10 + c-64]`. Codes 74..127 count nothing. A counter advances by one on each clock edge on which its selected input is high.
- R4: Code 73 on slots 2, 3 and 4 counts filtered read transactions, write transactions and read beats, in that slot order, and ignores `specEvt`. A filtered input counts when its valid is high, its enable is set, and (id AND mask) equals (programmed ID AND mask). The enables are bits 31 (read), 30 (write) and 29 (beat) of the word at 0x00, whose bits 17:0 are the mask. The programmed ID is bits 17:0 of the word at 0x04.
- R5: Slot n's local control word is at 0x50+0x10*n. Bit 31 is the local freeze, bit 26 arms the overflow condition and bits 22:16 are the select code. All other bits read zero. A locally frozen counter holds its value.
- R6: The global control word is at 0x40. Bit 31 is freeze-all, bit 30 is interrupt enable and bit 29 is freeze-on-condition enable. While freeze-all is set, no counter changes except through bus writes.
- R7: A write to a count register at 0x58+0x10*n loads the written value on the next edge. When that edge also carries an increment, the written value wins.
- R8: When an increment moves an armed counter's MSB from 0 to 1 while both global enables are set, freeze-all becomes 1 on that same edge and the whole bank stops.
- R9: `irq` is high exactly while both global enables are set and at least one armed counter has its MSB at 1. Clearing that MSB drops `irq`.
- R10: A freeze set by the hardware overrides a bus write that clears freeze-all on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| refEvt | input | 64 | Reference events shared by slots 1..10 |
| specEvt | input | 100 | Per-slot specific events, 10 per slot |
| rdTxnVld | input | 1 | Read transaction seen |
| rdTxnId | input | 18 | ID of that read transaction |
| wrTxnVld | input | 1 | Write transaction seen |
| wrTxnId | input | 18 | ID of that write transaction |
| rdBeatVld | input | 1 | Read data beat seen |
| rdBeatId | input | 18 | ID of that read beat |
| irq | output | 1 | Overflow interrupt level |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a software load of a count register and an increment of that same counter. The bench provokes it by holding the selected event high across a bus write, and it expects the written value to survive exactly. The second pair is a hardware overflow freeze and a software write that clears freeze-all. The bench holds a global-control write with freeze-all at 0 for two edges, so that the second edge is the one that carries the MSB rise. It then judges the outcome by reading back freeze-all as 1 and finding the counter stopped at 0x80000000.

// File: rtl/ebk_pkg.sv
`timescale 1ns/1ps
package ebk_pkg;
  localparam int EBK_NCTR = 11;
  localparam int EBK_DW   = 32;

  typedef struct packed {
    logic [EBK_NCTR-1:0] incEn;
    logic [EBK_NCTR-1:0] ldLo;
    logic                ldHi;
    logic [EBK_DW-1:0]   wrData;
  } ebk_strobe_t;
endpackage

// File: rtl/ebk_id_match.sv
`timescale 1ns/1ps
module ebk_id_match #(
  parameter int ID_W = 18
) (
  input  logic            vld,
  input  logic            en,
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] progId,
  input  logic [ID_W-1:0] mask,
  output logic            hit
);
  assign hit = vld & en & ((id & mask) == (progId & mask));
endmodule

// File: rtl/ebk_dpath.sv
`timescale 1ns/1ps
module ebk_dpath
  import ebk_pkg::*;
#(
  parameter int NCTR = EBK_NCTR,
  parameter int DW   = EBK_DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  ebk_strobe_t   strb,
  output logic [DW-1:0] cntLo [NCTR],
  output logic [DW-1:0] cycHi,
  output logic [NCTR-1:0] msbVec,
  output logic [NCTR-1:0] riseVec
);
  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [DW-1:0] HALF_MAX = {1'b0, {(DW-1){1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cycHi <= '0;
    else if (strb.ldHi)                 cycHi <= strb.wrData;
    else if (strb.ldLo[0])              cycHi <= cycHi;
    else if (strb.incEn[0] && cntLo[0] == ALL_ONES) cycHi <= cycHi + 1'b1;
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    logic hiLoad;
    assign hiLoad = (i == 0) ? strb.ldHi : 1'b0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cntLo[i] <= '0;
      else if (strb.ldLo[i])    cntLo[i] <= strb.wrData;
      else if (hiLoad)          cntLo[i] <= cntLo[i];
      else if (strb.incEn[i])   cntLo[i] <= cntLo[i] + 1'b1;
    end

    if (i == 0) begin : g_wide
      assign msbVec[i]  = cycHi[DW-1];
      assign riseVec[i] = strb.incEn[i] & ~strb.ldLo[i] & ~strb.ldHi &
                          (cycHi == HALF_MAX) & (cntLo[i] == ALL_ONES);
    end else begin : g_narrow
      assign msbVec[i]  = cntLo[i][DW-1];
      assign riseVec[i] = strb.incEn[i] & ~strb.ldLo[i] & (cntLo[i] == HALF_MAX);
    end

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.ldLo[i] |=> cntLo[i] == $past(strb.wrData));

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.incEn[i] && !strb.ldLo[i] && !hiLoad) |=> cntLo[i] == $past(cntLo[i]) + 1'b1);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.incEn[i] && !strb.ldLo[i] && !hiLoad) |=> $stable(cntLo[i]));
  end
endmodule

// File: rtl/ebk_ctrl.sv
`timescale 1ns/1ps
module ebk_ctrl
  import ebk_pkg::*;
#(
  parameter int NCTR     = EBK_NCTR,
  parameter int DW       = EBK_DW,
  parameter int NUM_REF  = 64,
  parameter int NUM_SPEC = 10,
  parameter int ID_W     = 18,
  parameter int SEL_W    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWe,
  input  logic [7:0]                  busAddr,
  input  logic [DW-1:0]               busWdata,
  output logic [DW-1:0]               busRdata,
  input  logic [NUM_REF-1:0]          refEvt,
  input  logic [(NCTR-1)*NUM_SPEC-1:0] specEvt,
  input  logic [2:0]                  fltVld,
  input  logic [ID_W-1:0]             fltId [3],
  input  logic [DW-1:0]               cntLo [NCTR],
  input  logic [DW-1:0]               cycHi,
  input  logic [NCTR-1:0]             msbVec,
  input  logic [NCTR-1:0]             riseVec,
  output ebk_strobe_t                 strb,
  output logic                        irq
);
  localparam logic [3:0] SLOT_BASE = 4'd5;
  localparam logic [3:0] NCTR4     = 4'(NCTR);
  localparam logic [SEL_W-1:0] FILT_CODE = SEL_W'(NUM_REF + NUM_SPEC - 1);

  logic gFac, gIe, gFce;
  logic [NCTR-1:0] lcFc, lcCe;
  logic [SEL_W-1:0] lcSel [NCTR];
  logic [2:0] fltEn;
  logic [ID_W-1:0] fltMask, fltProgId;

  logic [3:0] slot;
  logic slotOk, wrGlob, wrCfg1, wrCfg2, hwSet;
  logic [NCTR-1:0] evtHit;
  logic [2:0] fltHit;

  assign slot   = busAddr[7:4] - SLOT_BASE;
  assign slotOk = (busAddr[7:4] >= SLOT_BASE) && (slot < NCTR4);
  assign wrGlob = busWe && busAddr == 8'h40;
  assign wrCfg1 = busWe && busAddr == 8'h00;
  assign wrCfg2 = busWe && busAddr == 8'h04;

  for (genvar f = 0; f < 3; f++) begin : g_flt
    ebk_id_match #(.ID_W(ID_W)) u_match (
      .vld(fltVld[f]), .en(fltEn[f]), .id(fltId[f]),
      .progId(fltProgId), .mask(fltMask), .hit(fltHit[f])
    );
  end

  assign hwSet = gIe & gFce & |(riseVec & lcCe);
  assign irq   = gIe & gFce & |(msbVec & lcCe);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gFac <= 1'b0; gIe <= 1'b0; gFce <= 1'b0;
      fltEn <= '0; fltMask <= '0; fltProgId <= '0;
    end else begin
      if (hwSet)       gFac <= 1'b1;
      else if (wrGlob) gFac <= busWdata[31];
      if (wrGlob) begin
        gIe  <= busWdata[30];
        gFce <= busWdata[29];
      end
      if (wrCfg1) begin
        fltEn   <= {busWdata[29], busWdata[30], busWdata[31]};
        fltMask <= busWdata[ID_W-1:0];
      end
      if (wrCfg2) fltProgId <= busWdata[ID_W-1:0];
    end
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_slot
    logic wrLocal;
    assign wrLocal = busWe && slotOk && slot == 4'(i) && busAddr[3:0] == 4'h0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lcFc[i] <= 1'b0; lcCe[i] <= 1'b0; lcSel[i] <= '0;
      end else if (wrLocal) begin
        lcFc[i]  <= busWdata[31];
        lcCe[i]  <= busWdata[26];
        lcSel[i] <= busWdata[16 +: SEL_W];
      end
    end

    if (i == 0) begin : g_cyc
      assign evtHit[i] = 1'b1;
    end else begin : g_evt
      logic [NUM_SPEC-1:0] mySpec;
      logic [SEL_W-1:0]    code;
      logic                specHit;
      assign mySpec = specEvt[(i-1)*NUM_SPEC +: NUM_SPEC];
      assign code   = lcSel[i] - SEL_W'(NUM_REF);
      if (i >= 2 && i <= 4) begin : g_filt
        assign specHit = (lcSel[i] == FILT_CODE) ? fltHit[i-2] : mySpec[code[3:0]];
      end else begin : g_plain
        assign specHit = mySpec[code[3:0]];
      end
      always_comb begin
        if (lcSel[i] < SEL_W'(NUM_REF))       evtHit[i] = refEvt[lcSel[i][5:0]];
        else if (code < SEL_W'(NUM_SPEC))     evtHit[i] = specHit;
        else                                  evtHit[i] = 1'b0;
      end
    end

    assign strb.incEn[i] = ~gFac & ~lcFc[i] & evtHit[i];
    assign strb.ldLo[i]  = busWe && slotOk && slot == 4'(i) && busAddr[3:0] == 4'h8;
  end

  assign strb.ldHi   = busWe && busAddr == 8'h5C;
  assign strb.wrData = busWdata;

  always_comb begin
    busRdata = '0;
    if (busAddr == 8'h00)
      busRdata = {fltEn[0], fltEn[1], fltEn[2], {(DW-3-ID_W){1'b0}}, fltMask};
    else if (busAddr == 8'h04)
      busRdata = {{(DW-ID_W){1'b0}}, fltProgId};
    else if (busAddr == 8'h40)
      busRdata = {gFac, gIe, gFce, {(DW-3){1'b0}}};
    else if (slotOk) begin
      case (busAddr[3:0])
        4'h0: busRdata = {lcFc[slot], 4'b0, lcCe[slot], 3'b0, lcSel[slot], 16'b0};
        4'h8: busRdata = cntLo[slot];
        4'hC: busRdata = (slot == 4'd0) ? cycHi : '0;
        default: busRdata = '0;
      endcase
    end
  end

  // R8
  freeze_on_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    hwSet |=> gFac);

  // R9
  irq_needs_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (|(msbVec & lcCe)));
endmodule

// File: rtl/evt_ctr_bank.sv
`timescale 1ns/1ps
module evt_ctr_bank
  import ebk_pkg::*;
#(
  parameter int NUM_REF  = 64,
  parameter int NUM_SPEC = 10,
  parameter int ID_W     = 18
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWe,
  input  logic [7:0]                        busAddr,
  input  logic [EBK_DW-1:0]                 busWdata,
  output logic [EBK_DW-1:0]                 busRdata,
  input  logic [NUM_REF-1:0]                refEvt,
  input  logic [(EBK_NCTR-1)*NUM_SPEC-1:0]  specEvt,
  input  logic                              rdTxnVld,
  input  logic [ID_W-1:0]                   rdTxnId,
  input  logic                              wrTxnVld,
  input  logic [ID_W-1:0]                   wrTxnId,
  input  logic                              rdBeatVld,
  input  logic [ID_W-1:0]                   rdBeatId,
  output logic                              irq
);
  ebk_strobe_t strb;
  logic [EBK_DW-1:0] cntLo [EBK_NCTR];
  logic [EBK_DW-1:0] cycHi;
  logic [EBK_NCTR-1:0] msbVec, riseVec;
  logic [ID_W-1:0] fltId [3];

  assign fltId[0] = rdTxnId;
  assign fltId[1] = wrTxnId;
  assign fltId[2] = rdBeatId;

  ebk_ctrl #(.NUM_REF(NUM_REF), .NUM_SPEC(NUM_SPEC), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .refEvt(refEvt),
    .specEvt(specEvt), .fltVld({rdBeatVld, wrTxnVld, rdTxnVld}),
    .fltId(fltId), .cntLo(cntLo), .cycHi(cycHi), .msbVec(msbVec),
    .riseVec(riseVec), .strb(strb), .irq(irq)
  );

  ebk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cntLo(cntLo), .cycHi(cycHi),
    .msbVec(msbVec), .riseVec(riseVec)
  );
endmodule

// File: tb/evt_ctr_bank_tb_top.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] refEvt = '0;
  logic [99:0] specEvt = '0;
  logic rdTxnVld = 1'b0, wrTxnVld = 1'b0, rdBeatVld = 1'b0;
  logic [17:0] rdTxnId = '0, wrTxnId = '0, rdBeatId = '0;
  logic irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_ctr_bank dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .refEvt(refEvt),
    .specEvt(specEvt), .rdTxnVld(rdTxnVld), .rdTxnId(rdTxnId),
    .wrTxnVld(wrTxnVld), .wrTxnId(wrTxnId), .rdBeatVld(rdBeatVld),
    .rdBeatId(rdBeatId), .irq(irq)
  );

  function automatic logic [7:0] lcAddr(int n);  return 8'(8'h50 + 16*n); endfunction
  function automatic logic [7:0] cntAddr(int n); return 8'(8'h58 + 16*n); endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic pulse(logic [63:0] r, logic [99:0] s, int n);
    @(negedge clk);
    refEvt = r; specEvt = s;
    repeat (n) @(negedge clk);
    refEvt = '0; specEvt = '0;
  endtask

  initial begin
    logic [31:0] rd;
    int expR, expW, expB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(8'h40, rd); check("R1 global", rd, 32'h0);
    busRead(lcAddr(1), rd); check("R1 local1", rd, 32'h0);
    busRead(cntAddr(1), rd); check("R1 count1", rd, 32'h0);
    busRead(8'h00, rd); check("R1 cfg1", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 cycle counter
    busWrite(8'h40, 32'h8000_0000);
    busWrite(cntAddr(0), 32'h0);
    busWrite(8'h5C, 32'h0);
    busWrite(8'h40, 32'h0);
    repeat (10) @(negedge clk);
    busWrite(8'h40, 32'h8000_0000);
    busRead(cntAddr(0), rd); check("R2 cycles", rd, 32'd12);
    busRead(8'h5C, rd); check("R2 high word", rd, 32'h0);
    busWrite(8'h5C, 32'h0000_00A5);
    busRead(cntAddr(0), rd); check("R2 low kept on high write", rd, 32'd12);
    busWrite(lcAddr(0), 32'h8000_0000);
    busWrite(8'h40, 32'h0);
    repeat (8) @(negedge clk);
    busWrite(8'h40, 32'h8000_0000);
    busRead(cntAddr(0), rd); check("R2 local freeze slot0", rd, 32'd12);
    busWrite(lcAddr(0), 32'h0);
    busWrite(8'h40, 32'h0);

    // R3 reference events, exhaustive over codes
    for (int c = 0; c < 64; c++) begin
      busWrite(lcAddr(1), 32'(c) << 16);
      busWrite(cntAddr(1), 32'h0);
      pulse(64'(1) << c, '0, (c % 5) + 1);
      pulse(~(64'(1) << c), '1, 2);
      busRead(cntAddr(1), rd); check($sformatf("R3 ref code %0d", c), rd, 32'((c % 5) + 1));
    end

    // R3 specific events per slot
    for (int n = 1; n <= 10; n++) begin
      for (int c = 64; c <= 73; c++) begin
        if (c == 73 && n >= 2 && n <= 4) continue;
        busWrite(lcAddr(n), 32'(c) << 16);
        busWrite(cntAddr(n), 32'h0);
        pulse('0, 100'(1) << ((n - 1) * 10 + c - 64), c - 63);
        pulse('1, ~(100'(1) << ((n - 1) * 10 + c - 64)), 2);
        busRead(cntAddr(n), rd);
        check($sformatf("R3 slot %0d code %0d", n, c), rd, 32'(c - 63));
      end
    end
    busWrite(lcAddr(5), 32'd100 << 16);
    busWrite(cntAddr(5), 32'h0);
    pulse('1, '1, 4);
    busRead(cntAddr(5), rd); check("R3 unused code", rd, 32'h0);

    // R4 filtered transaction counts
    for (int n = 2; n <= 4; n++) begin
      busWrite(lcAddr(n), 32'd73 << 16);
      busWrite(cntAddr(n), 32'h0);
    end
    busWrite(8'h00, 32'hE000_00F0);
    busWrite(8'h04, 32'h0000_0050);
    busRead(8'h00, rd); check("R4 cfg1 readback", rd, 32'hE000_00F0);
    expR = 0; expW = 0; expB = 0;
    for (int j = 0; j < 24; j++) begin
      logic [17:0] ir, iw, ib;
      ir = 18'(j * 37 + 16'h0050);
      iw = 18'(j * 53);
      ib = 18'(j * 16);
      @(negedge clk);
      specEvt = '1;
      rdTxnVld = (j % 3) != 2; wrTxnVld = (j % 2) == 0; rdBeatVld = 1'b1;
      rdTxnId = ir; wrTxnId = iw; rdBeatId = ib;
      if (((j % 3) != 2) && ((ir & 18'h0F0) == 18'h050)) expR++;
      if (((j % 2) == 0) && ((iw & 18'h0F0) == 18'h050)) expW++;
      if ((ib & 18'h0F0) == 18'h050) expB++;
    end
    @(negedge clk);
    specEvt = '0; rdTxnVld = 0; wrTxnVld = 0; rdBeatVld = 0;
    busRead(cntAddr(2), rd); check("R4 read txn", rd, 32'(expR));
    busRead(cntAddr(3), rd); check("R4 write txn", rd, 32'(expW));
    busRead(cntAddr(4), rd); check("R4 read beat", rd, 32'(expB));
    busWrite(8'h00, 32'h0000_00F0);
    @(negedge clk);
    rdTxnVld = 1; wrTxnVld = 1; rdBeatVld = 1;
    rdTxnId = 18'h50; wrTxnId = 18'h50; rdBeatId = 18'h50;
    repeat (3) @(negedge clk);
    rdTxnVld = 0; wrTxnVld = 0; rdBeatVld = 0;
    busRead(cntAddr(2), rd); check("R4 filter off", rd, 32'(expR));

    // R5 local control
    busWrite(lcAddr(1), 32'hFFFF_FFFF);
    busRead(lcAddr(1), rd); check("R5 readback mask", rd, 32'h847F_0000);
    busWrite(lcAddr(1), 32'h8005_0000);
    busWrite(cntAddr(1), 32'h0);
    pulse(64'h20, '0, 4);
    busRead(cntAddr(1), rd); check("R5 local freeze", rd, 32'h0);

    // R6 global freeze outranks local
    busWrite(lcAddr(1), 32'h0005_0000);
    busWrite(8'h40, 32'h8000_0000);
    pulse(64'h20, '0, 4);
    busRead(cntAddr(1), rd); check("R6 global freeze", rd, 32'h0);
    busWrite(8'h40, 32'h0);
    pulse(64'h20, '0, 3);
    busRead(cntAddr(1), rd); check("R6 unfrozen", rd, 32'd3);

    // R7 load beats increment
    @(negedge clk); refEvt = 64'h20;
    busWrite(cntAddr(1), 32'd100);
    refEvt = '0;
    busRead(cntAddr(1), rd); check("R7 load wins", rd, 32'd100);

    // R8 / R9 overflow freezes the bank
    busWrite(8'h40, 32'hE000_0000);
    busWrite(lcAddr(1), 32'h0405_0000);
    busWrite(lcAddr(2), 32'h0005_0000);
    busWrite(cntAddr(1), 32'h7FFF_FFFE);
    busWrite(cntAddr(2), 32'h0);
    @(negedge clk); refEvt = 64'h20;
    busWrite(8'h40, 32'h6000_0000);
    repeat (5) @(negedge clk);
    refEvt = '0;
    busRead(cntAddr(1), rd); check("R8 overflow stop", rd, 32'h8000_0000);
    busRead(cntAddr(2), rd); check("R8 bank stop", rd, 32'd2);
    busRead(8'h40, rd); check("R8 freeze set", rd, 32'hE000_0000);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    busWrite(cntAddr(1), 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    busWrite(8'h40, 32'h6000_0000);
    busRead(8'h40, rd); check("R8 restart", rd, 32'h6000_0000);

    // R9 unarmed counter passes MSB without interrupt
    busWrite(lcAddr(1), 32'h0005_0000);
    busWrite(cntAddr(1), 32'h7FFF_FFFE);
    pulse(64'h20, '0, 3);
    busRead(cntAddr(1), rd); check("R9 unarmed count", rd, 32'h8000_0001);
    busRead(8'h40, rd); check("R9 unarmed no freeze", rd, 32'h6000_0000);
    check("R9 unarmed irq", {31'b0, irq}, 32'h0);
    busWrite(lcAddr(1), 32'h0405_0000);
    check("R9 level on arm", {31'b0, irq}, 32'h1);
    busWrite(cntAddr(1), 32'h0);

    // R8 on the 64-bit cycle counter
    busWrite(8'h40, 32'hE000_0000);
    busWrite(lcAddr(0), 32'h0400_0000);
    busWrite(8'h5C, 32'h7FFF_FFFF);
    busWrite(cntAddr(0), 32'hFFFF_FFFD);
    busWrite(8'h40, 32'h6000_0000);
    repeat (6) @(negedge clk);
    busRead(8'h5C, rd); check("R8 cycle high", rd, 32'h8000_0000);
    busRead(cntAddr(0), rd); check("R8 cycle low", rd, 32'h0);
    busRead(8'h40, rd); check("R8 cycle freeze", rd, 32'hE000_0000);
    busWrite(8'h5C, 32'h0);
    busWrite(lcAddr(0), 32'h0);

    // R10 hardware freeze beats software clear on the same edge
    busWrite(cntAddr(1), 32'h7FFF_FFFF);
    @(negedge clk);
    refEvt = 64'h20;
    busWe = 1'b1; busAddr = 8'h40; busWdata = 32'h6000_0000;
    @(negedge clk);
    @(negedge clk);
    busWe = 1'b0;
    repeat (3) @(negedge clk);
    refEvt = '0;
    busRead(8'h40, rd); check("R10 freeze kept", rd, 32'hE000_0000);
    busRead(cntAddr(1), rd); check("R10 count stopped", rd, 32'h8000_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule